// File: doc/BRIEF.md
# Gated Frequency Counter

This block measures the frequency of an external intermediate-frequency signal by counting its rising edges over a gate window of fixed length. The window length is a whole number of periods of a slow timebase; that timebase reaches the block as a one-cycle enable pulse, `tick_en`, which arrives once per 75 kHz period. Software writes a 4-bit control word. Its upper two bits pick the measurement mode and its lower two bits pick the gate time. A separate start pulse then launches a measurement. When the window closes, the count is copied into a 20-bit result register and a completion flag is raised. The next accepted start clears that flag.

The external signal is asynchronous to the block clock. It passes through a two-flop synchroniser and an edge detector before it reaches the counter. While the chip sits in a low-power or stopped mode, the `in_block` input masks every edge, so nothing is counted. The counter stops at all ones instead of wrapping.

The control FSM has four states. **IDLE** waits for a start. **WAIT** holds the cleared counter until the next timebase pulse, so that the window lines up with the timebase. **GATE** counts edges and timebase pulses until the selected length is used up. **STORE** loads the result and sets the flag. The transitions are:
- start accepted: any state → WAIT
- timebase pulse: WAIT → GATE
- final timebase pulse of the window: GATE → STORE
- unconditional: STORE → IDLE

Top module: `gated_freq_counter`

## Requirements
- R1: After reset, `result` is 0 and `done` is 0. The control word resets to 4'b0000, which selects frequency mode with the shortest gate.
- R2: Control bits [1:0] select the gate length in timebase pulses: 2'b00 = 75 (1 ms), 2'b01 = 300 (4 ms), 2'b10 = 600 (8 ms), 2'b11 = 2400 (32 ms). The window spans exactly that many timebase periods, starting after the first `tick_en` that follows the start.
- R3: A start is accepted only when control bits [3:2] equal 2'b00 (frequency mode). With any other mode, `start` is ignored: `done`, `result` and the FSM state do not change.
- R4: Writing the control word (`cfg_we`) never starts a measurement. Only a `start` pulse does.
- R5: Only rising edges of `sig_in` are counted, after two synchronising flops. A level that is held high adds nothing.
- R6: `done` rises, and `result` loads the count, on the clock edge that follows the edge which closes the gate. `result` holds its value at every other time.
- R7: An accepted start clears `done` and the counter on the next edge. This also happens in the middle of a running gate, which then restarts.
- R8: While `in_block` is high, no edge is counted.
- R9: The counter saturates at all ones (2^COUNT_W−1) and does not wrap. The default COUNT_W is 20.
- R10: The gate length is captured when the start is accepted. Writing the control word during a measurement does not change the window that is already running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle timebase pulse, once per 75 kHz period |
| cfg_we | input | 1 | Write strobe for the control word |
| cfg_data | input | 4 | Control word: [3:2] mode, [1:0] gate time |
| start | input | 1 | Start command pulse |
| in_block | input | 1 | High in low-power or stopped modes; masks counting |
| sig_in | input | 1 | External signal whose edges are counted |
| result | output | COUNT_W | Count latched at the end of the last completed gate |
| done | output | 1 | Completion flag |

## Verification
Each result appears a fixed number of clock edges after the stimulus that causes it:
- A rising level on `sig_in` that is sampled at edge k is added to the counter at edge k+2.
- `result` and `done` change one edge after the edge that carries the final timebase pulse of the window.
- `done` falls on the edge right after an accepted start.

The bench runs a behavioural reference model on the same rising edge as the design and compares every output at the falling edge, so each comparison sees values that have settled. The directed measurements use signal periods that divide the gate length exactly. This makes the expected count a closed-form number, whatever the phase between the signal and the timebase.

// File: rtl/gfc_pkg.sv
package gfc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_GATE,
        ST_STORE
    } gfc_state_e;

    localparam logic [1:0] MODE_FREQ = 2'b00;
endpackage

// File: rtl/gfc_edge_sync.sv
module gfc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_in,
    input  logic block,
    output logic rise
);
    logic [STAGES:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-1:0], sig_in};
    end

    assign rise = sh[STAGES-1] & ~sh[STAGES] & ~block;
endmodule

// File: rtl/gfc_gate_timer.sv
module gfc_gate_timer #(
    parameter int TIME_W = 12,
    parameter int LEN0   = 75,
    parameter int LEN1   = 300,
    parameter int LEN2   = 600,
    parameter int LEN3   = 2400
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [1:0] sel,
    input  logic       run,
    input  logic       tick,
    output logic       last
);
    logic [TIME_W-1:0] rem;
    logic [TIME_W-1:0] len_sel;

    always_comb begin
        unique case (sel)
            2'b00:   len_sel = TIME_W'(LEN0);
            2'b01:   len_sel = TIME_W'(LEN1);
            2'b10:   len_sel = TIME_W'(LEN2);
            default: len_sel = TIME_W'(LEN3);
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            rem <= '0;
        else if (load)         rem <= len_sel;
        else if (run && tick)  rem <= rem - TIME_W'(1);
    end

    assign last = run & tick & (rem == TIME_W'(1));

    // R10
    tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !(run && tick)) |=> $stable(rem));
endmodule

// File: rtl/gfc_sat_counter.sv
module gfc_sat_counter #(
    parameter int COUNT_W = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               inc,
    output logic [COUNT_W-1:0] q
);
    localparam logic [COUNT_W-1:0] TOP = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 q <= '0;
        else if (clr)               q <= '0;
        else if (inc && q != TOP)   q <= q + COUNT_W'(1);
    end

    // R9
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q == TOP && !clr) |=> (q == TOP));
    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !clr) |=> $stable(q));
endmodule

// File: rtl/gated_freq_counter.sv
module gated_freq_counter
    import gfc_pkg::*;
#(
    parameter int COUNT_W     = 20,
    parameter int SYNC_STAGES = 2,
    parameter int LEN0        = 75,
    parameter int LEN1        = 300,
    parameter int LEN2        = 600,
    parameter int LEN3        = 2400
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_en,
    input  logic               cfg_we,
    input  logic [3:0]         cfg_data,
    input  logic               start,
    input  logic               in_block,
    input  logic               sig_in,
    output logic [COUNT_W-1:0] result,
    output logic               done
);
    localparam int LEN_A   = (LEN0 > LEN1) ? LEN0 : LEN1;
    localparam int LEN_B   = (LEN2 > LEN3) ? LEN2 : LEN3;
    localparam int LEN_MAX = (LEN_A > LEN_B) ? LEN_A : LEN_B;
    localparam int TIME_W  = $clog2(LEN_MAX + 1);

    gfc_state_e         state, state_nx;
    logic [3:0]         cfg_q;
    logic               start_ok;
    logic               rise;
    logic               gate_last;
    logic [COUNT_W-1:0] cnt;

    assign start_ok = start & (cfg_q[3:2] == MODE_FREQ);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cfg_q <= 4'b0000;
        else if (cfg_we) cfg_q <= cfg_data;
    end

    gfc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_in (sig_in),
        .block  (in_block),
        .rise   (rise)
    );

    gfc_gate_timer #(
        .TIME_W (TIME_W),
        .LEN0   (LEN0),
        .LEN1   (LEN1),
        .LEN2   (LEN2),
        .LEN3   (LEN3)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (start_ok),
        .sel    (cfg_q[1:0]),
        .run    (state == ST_GATE),
        .tick   (tick_en),
        .last   (gate_last)
    );

    gfc_sat_counter #(.COUNT_W(COUNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (start_ok),
        .inc    ((state == ST_GATE) & rise),
        .q      (cnt)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        if (start_ok) begin
            state_nx = ST_WAIT;
        end else begin
            unique case (state)
                ST_IDLE:  state_nx = ST_IDLE;
                ST_WAIT:  if (tick_en)   state_nx = ST_GATE;
                ST_GATE:  if (gate_last) state_nx = ST_STORE;
                ST_STORE: state_nx = ST_IDLE;
                default:  state_nx = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result <= '0;
            done   <= 1'b0;
        end else if (start_ok) begin
            done   <= 1'b0;
        end else if (state == ST_STORE) begin
            result <= cnt;
            done   <= 1'b1;
        end
    end

    // R6
    done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(state) == ST_STORE));
    // R6
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_STORE) |=> $stable(result));
    // R7
    start_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_ok |=> (!done && state == ST_WAIT && cnt == '0));
    // R3
    bad_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && cfg_q[3:2] != MODE_FREQ && state == ST_IDLE) |=> (state == ST_IDLE));
    // R8
    blocked_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_block && !start_ok) |=> $stable(cnt));
endmodule

// File: tb/sim_gated_freq_counter.sv
module sim_gated_freq_counter;
    localparam int TK = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_data = 4'b0;
    logic        start = 1'b0;
    logic        in_block = 1'b0;
    logic        sig_in = 1'b0;
    logic [19:0] res0;
    logic        done0;
    logic [5:0]  res1;
    logic        done1;

    always #10 clk = ~clk;

    gated_freq_counter u0 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cfg_we(cfg_we),
        .cfg_data(cfg_data), .start(start), .in_block(in_block),
        .sig_in(sig_in), .result(res0), .done(done0));

    gated_freq_counter #(.COUNT_W(6)) u1 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cfg_we(cfg_we),
        .cfg_data(cfg_data), .start(start), .in_block(in_block),
        .sig_in(sig_in), .result(res1), .done(done1));

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // stimulus generator: timebase pulse every TK cycles, periodic signal
    int sig_per = 0;
    int pc = 0;
    int tc = 0;
    always @(negedge clk) begin
        tc = (tc + 1) % TK;
        tick_en = (tc == 0);
        if (sig_per < 2) begin
            sig_in = (sig_per == 1);
        end else begin
            pc = (pc + 1) % sig_per;
            sig_in = (pc < sig_per / 2);
        end
    end

    // reference model
    function automatic int gate_len(input logic [1:0] s);
        case (s)
            2'b00: return 75;
            2'b01: return 300;
            2'b10: return 600;
            default: return 2400;
        endcase
    endfunction

    int   m_state = 0;
    int   m_rem = 0;
    longint m_raw = 0;
    longint m_res = 0;
    bit   m_done = 0;
    logic [3:0] m_cfg = 4'b0;
    bit   ms1 = 0, ms2 = 0, ms3 = 0;

    always @(posedge clk) begin
        bit mrise;
        mrise = ms2 && !ms3 && !in_block;
        if (!rst_n) begin
            m_state = 0; m_rem = 0; m_raw = 0; m_res = 0; m_done = 0;
            m_cfg = 4'b0; ms1 = 0; ms2 = 0; ms3 = 0;
        end else begin
            if (start && m_cfg[3:2] == 2'b00) begin
                m_state = 1; m_raw = 0; m_done = 0; m_rem = gate_len(m_cfg[1:0]);
            end else begin
                case (m_state)
                    1: if (tick_en) m_state = 2;
                    2: begin
                        if (mrise) m_raw++;
                        if (tick_en) begin
                            if (m_rem == 1) m_state = 3;
                            else m_rem--;
                        end
                    end
                    3: begin m_res = m_raw; m_done = 1; m_state = 0; end
                    default: ;
                endcase
            end
            if (cfg_we) m_cfg = cfg_data;
            ms3 = ms2; ms2 = ms1; ms1 = sig_in;
        end
    end

    function automatic longint sat(input longint v, input int w);
        longint top;
        top = (longint'(1) << w) - 1;
        return (v > top) ? top : v;
    endfunction

    // cycle-by-cycle comparison
    always @(negedge clk) begin
        chk(res0 == sat(m_res, 20), "R6 result vs model", res0, sat(m_res, 20));
        chk(done0 == m_done, "R6 done vs model", done0, m_done);
        chk(res1 == sat(m_res, 6), "R9 narrow result vs model", res1, sat(m_res, 6));
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc >= 190000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic write_cfg(input logic [3:0] v);
        @(negedge clk); cfg_data = v; cfg_we = 1'b1;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_done(output int used);
        used = 0;
        while (!done0 && used < 20000) begin
            @(negedge clk);
            used++;
        end
        chk(done0 == 1'b1, "R6 done timeout", done0, 1);
    endtask

    task automatic measure(input logic [3:0] c, input int per, input string tag, input longint exp);
        int used;
        sig_per = per;
        write_cfg(c);
        pulse_start();
        wait_done(used);
        @(negedge clk);
        chk(res0 == exp, tag, res0, exp);
    endtask

    initial begin
        int used;
        logic [19:0] held;
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(res0 == 0, "R1 result at reset", res0, 0);
        chk(done0 == 0, "R1 done at reset", done0, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(done0 == 0, "R1 done after reset", done0, 0);

        // R1: default control word = frequency mode, 75-tick gate
        sig_per = 6;
        pulse_start();
        wait_done(used);
        @(negedge clk);
        chk(res0 == 75, "R1 default gate count", res0, 75);

        // R2: gate lengths
        measure(4'b0001, 6, "R2 gate 01", 300);
        measure(4'b0010, 3, "R2 gate 10", 1200);
        measure(4'b0011, 2, "R2 gate 11", 7200);
        measure(4'b0000, 2, "R2 gate 00 fast", 225);
        // R9: narrow instance saturates
        chk(res1 == 63, "R9 saturation", res1, 63);

        // R5: level held high counts nothing
        sig_per = 1;
        repeat (10) @(negedge clk);
        measure(4'b0000, 1, "R5 held level", 0);

        // R8: blocked input
        in_block = 1'b1;
        measure(4'b0000, 2, "R8 blocked", 0);
        in_block = 1'b0;

        // R3: non-frequency mode ignores start
        sig_per = 6;
        measure(4'b0000, 6, "R3 prep", 75);
        write_cfg(4'b0100);
        pulse_start();
        repeat (600) @(negedge clk);
        chk(done0 == 1, "R3 done kept", done0, 1);
        chk(res0 == 75, "R3 result kept", res0, 75);

        // R4: control write alone starts nothing
        sig_per = 2;
        write_cfg(4'b0000);
        repeat (600) @(negedge clk);
        chk(done0 == 1, "R4 done kept", done0, 1);
        chk(res0 == 75, "R4 result kept", res0, 75);

        // R7: start clears done, mid-gate restart
        sig_per = 6;
        pulse_start();
        chk(done0 == 0, "R7 done cleared", done0, 0);
        repeat (200) @(negedge clk);
        pulse_start();
        wait_done(used);
        @(negedge clk);
        chk(res0 == 75, "R7 restarted count", res0, 75);

        // R10: control write during gate keeps running length
        sig_per = 6;
        pulse_start();
        repeat (100) @(negedge clk);
        write_cfg(4'b0011);
        wait_done(used);
        chk(used < 75 * TK, "R10 window length", used, 75 * TK);
        @(negedge clk);
        chk(res0 == 75, "R10 count", res0, 75);

        // R6: result held after completion
        held = res0;
        sig_per = 2;
        repeat (100) @(negedge clk);
        chk(res0 == held, "R6 result held", res0, held);
        chk(done0 == 1, "R6 done held", done0, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule